// File: doc/BRIEF.md
# Grouped-Priority Interrupt Arbiter

This block arbitrates between a parameterised number of interrupt lines (16 by default) for a core that supports nested handlers. Each line holds a 4-bit urgency value, an enable flag, a pending flag and an active flag. A numerically smaller urgency value means a more urgent line. A global 3-bit grouping setting divides the urgency value into an upper pre-emption part and a lower tie-break part. The grouping can be changed at any time, and the next arbitration uses the new split.

Requests on `irq_req` are latched as pending. Every cycle the block picks the most urgent line that is both pending and enabled. It then decides whether that line may interrupt the handlers already running. When it may, the block raises `irq_valid` with the line number on `irq_id`. When the core answers with `irq_take`, the line moves from pending to active and is pushed onto an internal nesting stack. A pulse on `irq_done` retires the most recently accepted handler.

Software reaches all per-line state and the grouping setting through a single-cycle write/read port. It selects a field with `reg_sel` and a line with `reg_line`.

Top module: `gpa_arbiter`

## Requirements
- R1: After a synchronous active-low reset, every pending, active and enable flag is 0, every urgency value is 0, the grouping setting reads 0 and `irq_valid` is low.
- R2: A high `irq_req[i]` during a clock edge sets line i's pending flag. A write with `reg_sel`=3 sets the pending flag of `reg_line` when `reg_wdata[0]`=1 and clears it when `reg_wdata[0]`=0. A set from either source wins over a clear in the same cycle.
- R3: A line whose enable flag (written with `reg_sel`=2, `reg_wdata[0]`) is 0 keeps its pending flag but is never offered on `irq_valid`/`irq_id`.
- R4: Among pending enabled lines, the candidate has the smallest urgency value, and ties go to the lowest line index. Pre-emption part first, then tie-break part, gives the same order for every grouping.
- R5: Grouping value g gives 7-g pre-emption bits for g from 3 to 7, so g=7 gives none. Values 0 to 2 act like 3. The pre-emption part is the urgency value shifted right by the number of tie-break bits. The setting is written and read as `reg_wdata[2:0]`/`reg_rdata[2:0]` with `reg_sel`=0.
- R6: With no line active, any candidate raises `irq_valid`. Otherwise `irq_valid` is high only if the candidate's pre-emption part is strictly smaller than that of the most urgent active line.
- R7: While grouping gives zero pre-emption bits and any line is active, `irq_valid` stays low.
- R8: At an edge where `irq_valid` and `irq_take` are both high, line `irq_id` loses its pending flag and gains its active flag together. A request on that same line in that same cycle leaves the pending flag set.
- R9: A pulse on `irq_done` clears the active flag of the most recently accepted line that is still active (last in, first out). A pulse while no line is active changes nothing.
- R10: The active flag is read-only. A write with `reg_sel`=4 leaves it unchanged.
- R11: `reg_rdata` is combinational from `reg_sel` and `reg_line`. Select 0 returns the grouping, 1 the urgency value (bits 3:0), 2 the enable flag, 3 the pending flag and 4 the active flag, each in bit 0 unless stated. Selects 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | NUM_LINES | Per-line request, sampled each edge |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_sel | input | 3 | Field select (0 grouping, 1 urgency, 2 enable, 3 pending, 4 active) |
| reg_line | input | IDX_W | Line addressed by the register port |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for the current select and line |
| irq_valid | output | 1 | A line may be taken now |
| irq_id | output | IDX_W | Offered line, meaningful while irq_valid is high |
| irq_take | input | 1 | Core accepts the offered line |
| irq_done | input | 1 | Core finished the innermost handler |

## Verification
A corrupted pending or enable flag shows up in the first cycle after it is written: either the offer on `irq_valid`/`irq_id` changes, or the flag reads back wrong through the register port. A wrong nesting stack entry or a stuck active flag stays hidden until the matching `irq_done`. At that point the wrong line is retired, and later offers are blocked or wrongly allowed for as long as the stale active flag stays. The bench therefore compares the offer and a read-back every cycle against a behavioural model, across long nesting runs with grouping changes in the middle.

// File: rtl/gpa_pkg.sv
// Shared register-select codes and the grouping decode for the arbiter.
// Assumes a 3-bit grouping setting; values below 3 act like 3.
package gpa_pkg;

    typedef enum logic [2:0] {
        SEL_GROUP  = 3'd0,
        SEL_PRIO   = 3'd1,
        SEL_ENABLE = 3'd2,
        SEL_PEND   = 3'd3,
        SEL_ACTIVE = 3'd4
    } reg_sel_e;

    // Number of tie-break (low) bits of the urgency value for a grouping value.
    function automatic logic [2:0] tie_bits(input logic [2:0] grp);
        return (grp < 3'd3) ? 3'd0 : (grp - 3'd3);
    endfunction

endpackage

// File: rtl/gpa_line_bank.sv
// Per-line state: urgency value, enable, pending and active flags.
// Assumes that at most one accept and one retire happen per cycle and that
// they never address the same line (an active line is never offered).
module gpa_line_bank
    import gpa_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int PRIO_W    = 4,
    parameter int DATA_W    = 8,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_LINES-1:0]               irq_req,
    input  logic                               wr_en,
    input  logic [2:0]                         wr_sel,
    input  logic [IDX_W-1:0]                   wr_line,
    input  logic [DATA_W-1:0]                  wr_data,
    input  logic                               acc_en,
    input  logic [IDX_W-1:0]                   acc_id,
    input  logic                               clr_en,
    input  logic [IDX_W-1:0]                   clr_id,
    output logic [NUM_LINES-1:0]               pend,
    output logic [NUM_LINES-1:0]               en,
    output logic [NUM_LINES-1:0]               act,
    output logic [NUM_LINES-1:0][PRIO_W-1:0]   prio
);

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic hit;
        logic sw_set;
        logic sw_clr;
        logic take_me;

        assign hit     = wr_en && (wr_line == IDX_W'(i));
        assign sw_set  = hit && (wr_sel == SEL_PEND) && wr_data[0];
        assign sw_clr  = hit && (wr_sel == SEL_PEND) && !wr_data[0];
        assign take_me = acc_en && (acc_id == IDX_W'(i));

        // Configuration fields written from the register port.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prio[i] <= '0;
                en[i]   <= 1'b0;
            end else begin
                if (hit && wr_sel == SEL_PRIO)   prio[i] <= wr_data[PRIO_W-1:0];
                if (hit && wr_sel == SEL_ENABLE) en[i]   <= wr_data[0];
            end
        end

        // Pending flag: set sources dominate accept and software clear.
        always_ff @(posedge clk) begin
            if (!rst_n) pend[i] <= 1'b0;
            else        pend[i] <= (pend[i] && !take_me && !sw_clr) || irq_req[i] || sw_set;
        end

        // Active flag: set on accept, cleared on retire of this line.
        always_ff @(posedge clk) begin
            if (!rst_n)                                 act[i] <= 1'b0;
            else if (take_me)                           act[i] <= 1'b1;
            else if (clr_en && clr_id == IDX_W'(i))     act[i] <= 1'b0;
        end
    end

    // R8
    accept_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en |=> act[$past(acc_id)]);

    // R10
    act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_en && !clr_en) |=> $stable(act));

endmodule

// File: rtl/gpa_winner.sv
// Finds the candidate line with the smallest urgency value, lowest index on
// ties. Used both for the pending pick and for the most urgent active line.
module gpa_winner #(
    parameter int NUM_LINES = 16,
    parameter int PRIO_W    = 4,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic [NUM_LINES-1:0]             cand,
    input  logic [NUM_LINES-1:0][PRIO_W-1:0] prio,
    output logic                             found,
    output logic [IDX_W-1:0]                 idx,
    output logic [PRIO_W-1:0]                best
);

    // Ascending scan with strict compare keeps the lowest index on a tie.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (cand[i] && (!found || prio[i] < best)) begin
                found = 1'b1;
                idx   = IDX_W'(i);
                best  = prio[i];
            end
        end
    end

endmodule

// File: rtl/gpa_preempt_gate.sv
// Decides whether the pending pick may interrupt the running handlers by
// comparing pre-emption parts under the current grouping.
module gpa_preempt_gate
    import gpa_pkg::*;
#(
    parameter int PRIO_W = 4
) (
    input  logic [2:0]        grp,
    input  logic              win_found,
    input  logic [PRIO_W-1:0] win_prio,
    input  logic              act_found,
    input  logic [PRIO_W-1:0] act_prio,
    output logic              grant
);

    logic [2:0]        sh;
    logic [PRIO_W-1:0] win_pre;
    logic [PRIO_W-1:0] act_pre;

    // Strip the tie-break bits and compare what is left.
    always_comb begin
        sh      = tie_bits(grp);
        win_pre = win_prio >> sh;
        act_pre = act_prio >> sh;
        grant   = win_found && (!act_found || (win_pre < act_pre));
    end

endmodule

// File: rtl/gpa_nest_stack.sv
// LIFO of accepted line numbers; the top is the handler a retire pulse ends.
// Assumes no push while full (each entry is a distinct active line).
module gpa_nest_stack #(
    parameter int NUM_LINES = 16,
    localparam int IDX_W    = $clog2(NUM_LINES),
    localparam int CNT_W    = $clog2(NUM_LINES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [IDX_W-1:0] push_id,
    input  logic             pop,
    output logic             nonempty,
    output logic [IDX_W-1:0] top_id
);

    logic [IDX_W-1:0] slot [NUM_LINES];
    logic [CNT_W-1:0] depth;
    logic [CNT_W-1:0] tpos;
    logic             pop_ok;

    assign nonempty = (depth != '0);
    assign tpos     = depth - CNT_W'(1);
    assign top_id   = nonempty ? slot[tpos[IDX_W-1:0]] : '0;
    assign pop_ok   = pop && nonempty;

    // Replace the top on pop+push, otherwise grow or shrink by one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            depth <= '0;
            for (int i = 0; i < NUM_LINES; i++) slot[i] <= '0;
        end else if (pop_ok && push) begin
            slot[tpos[IDX_W-1:0]] <= push_id;
        end else if (push) begin
            slot[depth[IDX_W-1:0]] <= push_id;
            depth <= depth + CNT_W'(1);
        end else if (pop_ok) begin
            depth <= tpos;
        end
    end

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop_ok) |-> (depth < CNT_W'(NUM_LINES)));

    // R9
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !nonempty && !push) |=> (depth == '0));

endmodule

// File: rtl/gpa_arbiter.sv
// Top of the grouped-priority interrupt arbiter: grouping register, register
// read mux and the accept/retire handshake around the line bank and stack.
// Assumes irq_take is only meaningful while irq_valid is high.
module gpa_arbiter
    import gpa_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int PRIO_W    = 4,
    parameter int DATA_W    = 8,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_req,
    input  logic                 reg_wr,
    input  logic [2:0]           reg_sel,
    input  logic [IDX_W-1:0]     reg_line,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic                 irq_valid,
    output logic [IDX_W-1:0]     irq_id,
    input  logic                 irq_take,
    input  logic                 irq_done
);

    logic [2:0]                         grp_q;
    logic [NUM_LINES-1:0]               line_pend;
    logic [NUM_LINES-1:0]               line_en;
    logic [NUM_LINES-1:0]               line_act;
    logic [NUM_LINES-1:0][PRIO_W-1:0]   line_prio;
    logic                               win_found;
    logic [IDX_W-1:0]                   win_idx;
    logic [PRIO_W-1:0]                  win_prio;
    logic                               act_found;
    logic [IDX_W-1:0]                   act_idx;
    logic [PRIO_W-1:0]                  act_prio;
    logic                               grant;
    logic                               accept;
    logic                               stk_nonempty;
    logic [IDX_W-1:0]                   stk_top;
    logic                               done_fire;

    // Grouping setting, written through the register port.
    always_ff @(posedge clk) begin
        if (!rst_n)                              grp_q <= 3'd0;
        else if (reg_wr && reg_sel == SEL_GROUP) grp_q <= reg_wdata[2:0];
    end

    assign accept    = irq_valid && irq_take;
    assign done_fire = irq_done && stk_nonempty;
    assign irq_valid = grant;
    assign irq_id    = win_idx;

    gpa_line_bank #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W), .DATA_W(DATA_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_req (irq_req),
        .wr_en   (reg_wr),
        .wr_sel  (reg_sel),
        .wr_line (reg_line),
        .wr_data (reg_wdata),
        .acc_en  (accept),
        .acc_id  (win_idx),
        .clr_en  (done_fire),
        .clr_id  (stk_top),
        .pend    (line_pend),
        .en      (line_en),
        .act     (line_act),
        .prio    (line_prio)
    );

    gpa_winner #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W)) u_pick_pend (
        .cand  (line_pend & line_en),
        .prio  (line_prio),
        .found (win_found),
        .idx   (win_idx),
        .best  (win_prio)
    );

    gpa_winner #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W)) u_pick_act (
        .cand  (line_act),
        .prio  (line_prio),
        .found (act_found),
        .idx   (act_idx),
        .best  (act_prio)
    );

    gpa_preempt_gate #(.PRIO_W(PRIO_W)) u_gate (
        .grp       (grp_q),
        .win_found (win_found),
        .win_prio  (win_prio),
        .act_found (act_found),
        .act_prio  (act_prio),
        .grant     (grant)
    );

    gpa_nest_stack #(.NUM_LINES(NUM_LINES)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (accept),
        .push_id  (win_idx),
        .pop      (irq_done),
        .nonempty (stk_nonempty),
        .top_id   (stk_top)
    );

    // Register read mux, combinational from select and line.
    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            SEL_GROUP:  reg_rdata[2:0]        = grp_q;
            SEL_PRIO:   reg_rdata[PRIO_W-1:0] = line_prio[reg_line];
            SEL_ENABLE: reg_rdata[0]          = line_en[reg_line];
            SEL_PEND:   reg_rdata[0]          = line_pend[reg_line];
            SEL_ACTIVE: reg_rdata[0]          = line_act[reg_line];
            default:    reg_rdata             = '0;
        endcase
    end

    // R3
    offer_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (line_en[irq_id] && line_pend[irq_id] && !line_act[irq_id]));

    // R7
    flat_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_q == 3'd7 && (|line_act)) |-> !irq_valid);

    // R9
    done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_fire |=> !line_act[$past(stk_top)]);

    // R6
    idle_accepts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((line_act == '0) && (|(line_pend & line_en))) |-> irq_valid);

endmodule

// File: tb/gpa_arbiter_tb_top.sv
`timescale 1ns/100ps
module gpa_arbiter_tb_top;

    localparam int NL = 16;
    localparam int IW = 4;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] irq_req = '0;
    logic          reg_wr = 1'b0;
    logic [2:0]    reg_sel = 3'd0;
    logic [IW-1:0] reg_line = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          irq_valid;
    logic [IW-1:0] irq_id;
    logic          irq_take = 1'b0;
    logic          irq_done = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    gpa_arbiter #(.NUM_LINES(NL), .PRIO_W(4), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .reg_wr(reg_wr),
        .reg_sel(reg_sel), .reg_line(reg_line), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_valid(irq_valid), .irq_id(irq_id),
        .irq_take(irq_take), .irq_done(irq_done)
    );

    // ---------------- behavioural reference model ----------------
    int m_prio [NL];
    bit m_en   [NL];
    bit m_pend [NL];
    bit m_act  [NL];
    int m_grp;
    int m_stk[$];
    bit e_valid;
    int e_id;

    function automatic void m_reset();
        for (int i = 0; i < NL; i++) begin
            m_prio[i] = 0; m_en[i] = 0; m_pend[i] = 0; m_act[i] = 0;
        end
        m_grp = 0;
        m_stk.delete();
    endfunction

    function automatic void m_eval();
        int bp;
        int mp;
        int g;
        int s;
        bp = -1; mp = -1; e_valid = 0; e_id = 0;
        for (int i = 0; i < NL; i++)
            if (m_pend[i] && m_en[i] && (bp < 0 || m_prio[i] < bp)) begin
                bp = m_prio[i]; e_id = i;
            end
        for (int i = 0; i < NL; i++)
            if (m_act[i] && (mp < 0 || m_prio[i] < mp)) mp = m_prio[i];
        if (bp >= 0) begin
            if (mp < 0) e_valid = 1;
            else begin
                g = (m_grp < 3) ? 3 : m_grp;
                s = g - 3;
                e_valid = ((bp >> s) < (mp >> s));
            end
        end
    endfunction

    function automatic int m_read(int sel, int line);
        case (sel)
            0: return m_grp;
            1: return m_prio[line];
            2: return int'(m_en[line]);
            3: return int'(m_pend[line]);
            4: return int'(m_act[line]);
            default: return 0;
        endcase
    endfunction

    function automatic void m_step();
        bit acc;
        int ln;
        m_eval();
        acc = irq_take && e_valid;
        ln = int'(reg_line);
        for (int i = 0; i < NL; i++) begin
            bit np;
            np = m_pend[i];
            if (acc && e_id == i) np = 0;
            if (reg_wr && reg_sel == 3'd3 && ln == i && !reg_wdata[0]) np = 0;
            if (reg_wr && reg_sel == 3'd3 && ln == i && reg_wdata[0]) np = 1;
            if (irq_req[i]) np = 1;
            m_pend[i] = np;
        end
        if (reg_wr && reg_sel == 3'd0) m_grp = int'(reg_wdata[2:0]);
        if (reg_wr && reg_sel == 3'd1) m_prio[ln] = int'(reg_wdata[3:0]);
        if (reg_wr && reg_sel == 3'd2) m_en[ln] = reg_wdata[0];
        if (irq_done && m_stk.size() > 0) begin
            m_act[m_stk[$]] = 0;
            void'(m_stk.pop_back());
        end
        if (acc) begin
            m_act[e_id] = 1;
            m_stk.push_back(e_id);
        end
    endfunction

    // ---------------- checking ----------------
    task automatic check(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        m_eval();
        check(cur_req, "irq_valid", int'(irq_valid), int'(e_valid));
        if (e_valid && irq_valid) check(cur_req, "irq_id", int'(irq_id), e_id);
        check("R11", "reg_rdata", int'(reg_rdata), m_read(int'(reg_sel), int'(reg_line)));
    endtask

    task automatic tick();
        if (!rst_n) m_reset(); else m_step();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(int sel, int line, int data);
        reg_wr = 1'b1; reg_sel = 3'(sel); reg_line = IW'(line); reg_wdata = DW'(data);
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(string req, int sel, int line, int exp);
        reg_sel = 3'(sel); reg_line = IW'(line);
        #1;
        check(req, "read-back", int'(reg_rdata), exp);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        @(negedge clk);
        tick(); tick(); tick();
        rst_n = 1'b1;
        // R1: reset state
        cur_req = "R1";
        check("R1", "irq_valid after reset", int'(irq_valid), 0);
        rd_chk("R1", 0, 0, 0);
        rd_chk("R1", 3, 0, 0);
        rd_chk("R1", 2, 7, 0);

        // R10: active flag is read-only
        cur_req = "R10";
        wr(4, 3, 1);
        rd_chk("R10", 4, 3, 0);

        // R2 / R3: software pending on a disabled line
        cur_req = "R3";
        wr(3, 4, 1);
        rd_chk("R2", 3, 4, 1);
        check("R3", "disabled line offered", int'(irq_valid), 0);
        cur_req = "R2";
        irq_req[6] = 1'b1; tick(); irq_req[6] = 1'b0;
        rd_chk("R2", 3, 6, 1);
        reg_wr = 1'b1; reg_sel = 3'd3; reg_line = 4'd6; reg_wdata = 8'd0;
        irq_req[6] = 1'b1; tick(); irq_req[6] = 1'b0; reg_wr = 1'b0;
        rd_chk("R2", 3, 6, 1);
        wr(3, 6, 0);
        rd_chk("R2", 3, 6, 0);
        wr(3, 4, 0);

        // R4: selection order
        cur_req = "R4";
        wr(1, 2, 7); wr(1, 5, 3); wr(1, 9, 3); wr(1, 12, 1);
        for (int i = 0; i < NL; i++) wr(2, i, 1);
        rd_chk("R11", 1, 5, 3);
        irq_req[2] = 1'b1; irq_req[5] = 1'b1; irq_req[9] = 1'b1;
        tick();
        irq_req = '0;
        check("R4", "offer valid", int'(irq_valid), 1);
        check("R4", "offer id", int'(irq_id), 5);

        // R8 / R6: accept, then equal urgency cannot pre-empt
        cur_req = "R8";
        irq_take = 1'b1; tick(); irq_take = 1'b0;
        rd_chk("R8", 4, 5, 1);
        rd_chk("R8", 3, 5, 0);
        check("R6", "equal urgency blocked", int'(irq_valid), 0);
        cur_req = "R6";
        irq_req[12] = 1'b1; tick(); irq_req = '0;
        check("R6", "more urgent offered", int'(irq_id), 12);
        irq_take = 1'b1; tick(); irq_take = 1'b0;

        // R5 / R7: grouping changes at run time
        cur_req = "R7";
        wr(0, 0, 7);
        irq_req[0] = 1'b1; tick(); irq_req = '0;
        check("R7", "no pre-emption bits", int'(irq_valid), 0);
        rd_chk("R5", 0, 0, 7);
        cur_req = "R5";
        wr(0, 0, 1);
        check("R5", "grouping 1 acts as 3", int'(irq_valid), 1);
        check("R5", "grouping 1 id", int'(irq_id), 0);
        wr(0, 0, 6);
        check("R5", "one pre-emption bit", int'(irq_valid), 0);
        wr(0, 0, 3);
        check("R5", "four pre-emption bits", int'(irq_valid), 1);
        irq_take = 1'b1; tick(); irq_take = 1'b0;

        // R9: last in, first out retire
        cur_req = "R9";
        irq_done = 1'b1; tick(); irq_done = 1'b0;
        rd_chk("R9", 4, 0, 0);
        rd_chk("R9", 4, 12, 1);
        irq_done = 1'b1; tick(); irq_done = 1'b0;
        rd_chk("R9", 4, 12, 0);
        check("R9", "still blocked by line 5", int'(irq_valid), 0);
        irq_done = 1'b1; tick(); irq_done = 1'b0;
        check("R9", "offer after retire", int'(irq_id), 9);
        irq_take = 1'b1; tick(); irq_take = 1'b0;
        irq_done = 1'b1; tick(); tick(); irq_done = 1'b0;
        check("R9", "empty retire harmless", int'(irq_id), 2);

        // R8: request on the accepted line in the accept cycle
        cur_req = "R8";
        irq_req[2] = 1'b1; irq_take = 1'b1; tick(); irq_req = '0; irq_take = 1'b0;
        rd_chk("R8", 3, 2, 1);
        rd_chk("R8", 4, 2, 1);
        check("R8", "re-pended active line not offered", int'(irq_valid), 0);
        irq_done = 1'b1; tick(); irq_done = 1'b0;

        // Mixed traffic compared each cycle against the model
        cur_req = "R4 R6 R8 R9";
        for (int c = 0; c < 4000; c++) begin
            for (int i = 0; i < NL; i++) irq_req[i] = ($urandom_range(0, 19) == 0);
            irq_take = ($urandom_range(0, 1) == 1);
            irq_done = ($urandom_range(0, 5) == 0);
            reg_wr   = ($urandom_range(0, 9) == 0);
            reg_sel  = 3'($urandom_range(0, 5));
            reg_line = IW'($urandom_range(0, NL - 1));
            reg_wdata = DW'($urandom_range(0, 255));
            if (reg_wr && reg_sel == 3'd2) reg_wdata[0] = ($urandom_range(0, 3) != 0);
            tick();
        end
        irq_req = '0; irq_take = 1'b0; irq_done = 1'b0; reg_wr = 1'b0;
        tick();

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule